// File: doc/BRIEF.md
# Coprocessor Result Channel Arbiter

This block gathers scalar results produced inside a vector coprocessor and hands them back to the host core over one result channel. The channel uses a valid/ready handshake, and each transaction carries an instruction id and a data word. Results come from two producers:

- **Buffered CSR source.** It presents id and data together and is held in a single-entry slot.
- **Late-data source.** It presents only the id when the result is granted. The matching data word arrives on a separate bus in the following cycle and is present there for that one cycle only.

The outgoing id, data and valid come from an output register. That register reloads only when the channel is empty or when its current transaction completes in the same cycle. The host may therefore hold ready low for any number of cycles without the offered transaction changing.

When both producers have a result waiting, the late-data source goes first. Each producer sees its own ready output, which is high only while its slot is free. A result on a producer is taken only in a cycle where that producer's valid and ready are both high.

Top module: `coproc_result_arb`

## Requirements
- R1: After reset, `res_valid_o` is 0, and `csr_ready_o` and `late_ready_o` are both 1.
- R2: Every result accepted from either source is delivered exactly once on the result channel with its own id and data. Results from the same source are delivered in their acceptance order.
- R3: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_id_o` keeps its value into the next cycle.
- R4: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_data_o` keeps its value into the next cycle.
- R5: While a buffered CSR result waits, `csr_ready_o` is 0. Id and data offered on the CSR source in that time are ignored and never reach the channel.
- R6: The data of a late-data result is the value on `late_data_i` in the cycle right after the id was accepted. Values on `late_data_i` in any other cycle never reach the channel.
- R7: When the output register can load and both sources hold a result, the late-data result is loaded first.
- R8: While a late-data result waits, `late_ready_o` is 0.
- R9: Once `res_valid_o` is 1, it stays 1 until a cycle in which `res_ready_i` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_valid_i | input | 1 | Buffered CSR source has a result |
| csr_ready_o | output | 1 | CSR slot can accept this cycle |
| csr_id_i | input | ID_W | CSR result instruction id |
| csr_data_i | input | DATA_W | CSR result data |
| late_valid_i | input | 1 | Late-data source requests a result slot |
| late_ready_o | output | 1 | Late-data slot can accept this cycle |
| late_id_i | input | ID_W | Late-data result instruction id |
| late_data_i | input | DATA_W | Late-data word, valid one cycle after id acceptance |
| res_valid_o | output | 1 | Result transaction offered to host |
| res_ready_i | input | 1 | Host accepts result |
| res_id_o | output | ID_W | Result instruction id |
| res_data_o | output | DATA_W | Result data |

## Verification
The hardest case to reach is a stall during which both internal slots fill behind a waiting output transaction, while the late-data bus keeps changing after its one valid cycle. Stale data or a slot overwrite would then corrupt a transaction already in flight.

The stimulus holds host ready low for random stretches and offers both sources with random valid patterns. It drives marked junk values on every id or data input that must not be captured, so any leak shows up as a foreign pair on the channel. A directed sequence fills the output register, the CSR slot and the late-data slot in turn, then releases ready to check the delivery order.

// File: rtl/coproc_result_pkg.sv
package coproc_result_pkg;
  localparam int unsigned ID_W   = 8;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } res_ent_t;
endpackage

// File: rtl/csr_result_slot.sv
module csr_result_slot
  import coproc_result_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  output logic            wr_ready_o,
  input  logic [ID_W-1:0] wr_id_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic            take_i,
  output logic            pend_o,
  output res_ent_t        ent_o
);
  logic     v_q;
  res_ent_t ent_q;

  // slot writable only when empty: a waiting entry is never overwritten
  assign wr_ready_o = !v_q;
  assign pend_o     = v_q;
  assign ent_o      = ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      ent_q <= '0;
    end else if (wr_valid_i && wr_ready_o) begin
      v_q   <= 1'b1;
      ent_q <= '{id: wr_id_i, data: wr_data_i};
    end else if (take_i) begin
      v_q <= 1'b0;
    end
  end

  a_r5_slot_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !take_i) |=> (v_q && $stable(ent_q)));
  a_r5_no_ready_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> !wr_ready_o);
endmodule

// File: rtl/late_csr_stage.sv
module late_csr_stage
  import coproc_result_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  output logic              acc_ready_o,
  input  logic [ID_W-1:0]   acc_id_i,
  input  logic [DATA_W-1:0] late_data_i,
  input  logic              take_i,
  output logic              pend_o,
  output res_ent_t          ent_o
);
  logic              v_q, has_d_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] data_q;

  assign acc_ready_o = !v_q;
  assign pend_o      = v_q;
  // in the arrival cycle the data comes straight from the bus, afterwards from the hold register
  assign ent_o       = '{id: id_q, data: (has_d_q ? data_q : late_data_i)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q     <= 1'b0;
      has_d_q <= 1'b0;
      id_q    <= '0;
      data_q  <= '0;
    end else if (acc_valid_i && acc_ready_o) begin
      v_q     <= 1'b1;
      has_d_q <= 1'b0;
      id_q    <= acc_id_i;
    end else if (take_i) begin
      v_q     <= 1'b0;
      has_d_q <= 1'b0;
    end else if (v_q && !has_d_q) begin
      // capture once, in the arrival cycle only
      has_d_q <= 1'b1;
      data_q  <= late_data_i;
    end
  end

  a_r6_data_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && has_d_q && !take_i) |=> (v_q && $stable(data_q) && $stable(id_q)));
  a_r8_ready_low_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_ready_o) |=> (!acc_ready_o && !has_d_q));
endmodule

// File: rtl/result_out_reg.sv
module result_out_reg
  import coproc_result_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  res_ent_t load_ent_i,
  input  logic     ready_i,
  output logic     free_o,
  output logic     valid_o,
  output res_ent_t ent_o
);
  logic     v_q;
  res_ent_t ent_q;

  assign free_o  = !v_q || ready_i;
  assign valid_o = v_q;
  assign ent_o   = ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= 1'b0;
      ent_q <= '0;
    end else if (free_o) begin
      v_q <= load_i;
      if (load_i) ent_q <= load_ent_i;
    end
  end

  a_r3_id_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !ready_i) |=> $stable(ent_q.id));
  a_r4_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !ready_i) |=> $stable(ent_q.data));
  a_r9_valid_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && !ready_i) |=> v_q);
endmodule

// File: rtl/coproc_result_arb.sv
module coproc_result_arb
  import coproc_result_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              csr_valid_i,
  output logic              csr_ready_o,
  input  logic [ID_W-1:0]   csr_id_i,
  input  logic [DATA_W-1:0] csr_data_i,
  input  logic              late_valid_i,
  output logic              late_ready_o,
  input  logic [ID_W-1:0]   late_id_i,
  input  logic [DATA_W-1:0] late_data_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [ID_W-1:0]   res_id_o,
  output logic [DATA_W-1:0] res_data_o
);
  logic     csr_pend, late_pend, out_free, take_csr, take_late, load;
  res_ent_t csr_ent, late_ent, load_ent, out_ent;

  csr_result_slot u_csr_slot (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (csr_valid_i),
    .wr_ready_o (csr_ready_o),
    .wr_id_i    (csr_id_i),
    .wr_data_i  (csr_data_i),
    .take_i     (take_csr),
    .pend_o     (csr_pend),
    .ent_o      (csr_ent)
  );

  late_csr_stage u_late_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (late_valid_i),
    .acc_ready_o (late_ready_o),
    .acc_id_i    (late_id_i),
    .late_data_i (late_data_i),
    .take_i      (take_late),
    .pend_o      (late_pend),
    .ent_o       (late_ent)
  );

  // fixed priority: late-data path first
  assign take_late = out_free && late_pend;
  assign take_csr  = out_free && csr_pend && !late_pend;
  assign load      = take_late || take_csr;
  assign load_ent  = late_pend ? late_ent : csr_ent;

  result_out_reg u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_ent_i (load_ent),
    .ready_i    (res_ready_i),
    .free_o     (out_free),
    .valid_o    (res_valid_o),
    .ent_o      (out_ent)
  );

  assign res_id_o   = out_ent.id;
  assign res_data_o = out_ent.data;

  a_r7_late_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_free && late_pend && csr_pend) |=> (res_valid_o && res_id_o == $past(late_ent.id) && csr_pend));
  a_r2_one_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_late && take_csr));
endmodule

// File: tb/tb_coproc_result_arb.sv
module tb_coproc_result_arb;
  import coproc_result_pkg::*;

  localparam int unsigned PW       = ID_W + DATA_W;
  localparam int unsigned WD_LIMIT = 150000;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              csr_valid_i = 1'b0, late_valid_i = 1'b0, res_ready_i = 1'b0;
  logic [ID_W-1:0]   csr_id_i = '0, late_id_i = '0;
  logic [DATA_W-1:0] csr_data_i = '0, late_data_i = '0;
  logic              csr_ready_o, late_ready_o, res_valid_o;
  logic [ID_W-1:0]   res_id_o;
  logic [DATA_W-1:0] res_data_o;

  always #2 clk_i = ~clk_i;

  coproc_result_arb dut (.*);

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  logic [PW-1:0] q_csr[$], q_late[$];
  logic [ID_W-1:0] next_id = '0;
  bit late_due = 0;
  logic [DATA_W-1:0] late_due_data;
  bit prev_stall = 0;
  logic [ID_W-1:0] prev_id;
  logic [DATA_W-1:0] prev_data;
  int last_src = -1;

  function automatic logic [ID_W-1:0] new_id();
    logic [ID_W-1:0] r = next_id;
    next_id = next_id + 1'b1;
    if (next_id == '1) next_id = '0;  // all-ones id is reserved for junk
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pop_check(input logic [PW-1:0] p);
    n_chk++;
    if (q_late.size() > 0 && q_late[0] == p) begin
      void'(q_late.pop_front()); last_src = 1;
    end else if (q_csr.size() > 0 && q_csr[0] == p) begin
      void'(q_csr.pop_front()); last_src = 0;
    end else begin
      n_fail++; last_src = -1;
      if (p[DATA_W-1 -: 16] == 16'hDEAD)
        $display("FAIL R5 actual=%0h expected=no junk CSR pair", p);
      else if (p[DATA_W-1 -: 12] == 12'hBAD)
        $display("FAIL R6 actual=%0h expected=captured late data", p);
      else
        $display("FAIL R2 actual=%0h expected=%0h or %0h", p,
                 (q_late.size() > 0) ? q_late[0] : '0, (q_csr.size() > 0) ? q_csr[0] : '0);
    end
  endtask

  // called just after a negedge; drives one cycle and returns at the next negedge
  task automatic step(input bit cv, input bit lv, input bit rr);
    logic [DATA_W-1:0] d;
    logic [ID_W-1:0] id;
    if (prev_stall) begin
      chk(res_valid_o == 1'b1, "R9 valid held", 64'(res_valid_o), 64'd1);
      chk(res_id_o == prev_id, "R3 id stable", 64'(res_id_o), 64'(prev_id));
      chk(res_data_o == prev_data, "R4 data stable", 64'(res_data_o), 64'(prev_data));
    end
    res_ready_i = rr;
    if (res_valid_o && rr) pop_check({res_id_o, res_data_o});
    prev_stall = res_valid_o && !rr;
    prev_id    = res_id_o;
    prev_data  = res_data_o;
    csr_valid_i = cv;
    if (cv && csr_ready_o) begin
      id = new_id(); d = $urandom & 32'h7FFF_FFFF;
      csr_id_i = id; csr_data_i = d;
      q_csr.push_back({id, d});
    end else begin
      csr_id_i = '1; csr_data_i = 32'hDEAD_BEEF;
    end
    late_data_i = late_due ? late_due_data : (32'hBAD0_0000 | ($urandom & 32'hFFFF));
    late_due = 0;
    late_valid_i = lv;
    if (lv && late_ready_o) begin
      id = new_id(); d = $urandom & 32'h7FFF_FFFF;
      late_id_i = id;
      q_late.push_back({id, d});
      late_due = 1; late_due_data = d;
    end else begin
      late_id_i = '1;
    end
    @(negedge clk_i);
    n_cyc++;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    chk(res_valid_o == 1'b0, "R1 res_valid_o", 64'(res_valid_o), 64'd0);
    chk(csr_ready_o == 1'b1, "R1 csr_ready_o", 64'(csr_ready_o), 64'd1);
    chk(late_ready_o == 1'b1, "R1 late_ready_o", 64'(late_ready_o), 64'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed R7/R5/R8: fill output, CSR slot and late slot under stall
    step(1, 0, 0);                 // A -> CSR slot
    step(0, 0, 0);                 // A -> output
    step(1, 0, 0);                 // B -> CSR slot
    chk(csr_ready_o == 1'b0, "R5 csr_ready_o low while full", 64'(csr_ready_o), 64'd0);
    step(1, 1, 0);                 // C -> late slot, CSR junk offered
    chk(late_ready_o == 1'b0, "R8 late_ready_o low while pending", 64'(late_ready_o), 64'd0);
    step(0, 1, 0);                 // data of C arrives, late junk id offered
    step(0, 0, 0);                 // bus now junk
    step(0, 0, 1);                 // A handshakes
    chk(last_src == 0, "R2 first result from CSR", 64'(last_src), 64'd0);
    step(0, 0, 1);
    chk(last_src == 1, "R7 late result before CSR", 64'(last_src), 64'd1);
    step(0, 0, 1);
    chk(last_src == 0, "R7 CSR result after late", 64'(last_src), 64'd0);

    // directed R6: late result loaded straight from bus in arrival cycle, then stalled
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(0, 0, 1);
    chk(last_src == 1, "R6 late result delivered", 64'(last_src), 64'd1);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      int hold = $urandom_range(0, 9);
      bit cv, lv;
      for (int k = 0; k <= hold; k++) begin
        cv = ($urandom_range(0, 99) < 45);
        lv = ($urandom_range(0, 99) < 35);
        step(cv, lv, (k == hold) ? 1'b1 : ($urandom_range(0, 3) == 0));
      end
      if (n_cyc > 60000) break;
    end

    // drain
    for (int i = 0; i < 50; i++) step(0, 0, 1);
    chk(q_csr.size() == 0, "R2 all CSR results delivered", 64'(q_csr.size()), 64'd0);
    chk(q_late.size() == 0, "R2 all late results delivered", 64'(q_late.size()), 64'd0);
    chk(res_valid_o == 1'b0, "R2 channel idle after drain", 64'(res_valid_o), 64'd0);
    finish_run();
  end

  initial begin
    int w = 0;
    while (w < WD_LIMIT) begin
      @(posedge clk_i);
      w++;
    end
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", w, WD_LIMIT);
    finish_run();
  end
endmodule